// File: doc/BRIEF.md
# Power-On Self-Test Sequencer

This block runs once after reset and decides whether the processor may start. When reset is released it samples a test-enable input. If the input is high, it starts an internal test engine and waits for that engine's verdict. If the input is low, it skips that phase. In both cases it then runs a bus integrity check. The check reads a fixed number of 32-bit words from a boot record through a simple read port. It adds the words to an all-ones seed with wraparound arithmetic, and it passes only if the total is zero.

The active-low fail output is held low during every test phase, including a skipped one. It is released briefly between a passing internal test and the bus check, and released for good once the bus check passes. At that point a run signal tells the later boot stages to proceed. Any failure halts the block until the next reset, with fail held low and a failure code held on the address bus. An external system-error input pulls the fail output low while it is high, without changing the sequence.

Top module: `selftest_seq`

## Requirements
- R1: While reset is low, and in the first cycle after its release, `fail_n` is 0. In that same window `run_ok`, `rd_req` and `bist_start` are 0.
- R2: `test_en` is captured at the first rising clock edge after `rst_n` goes high. If it was 1, `bist_start` is high from the next cycle until the clock edge that accepts `bist_done`. Changes to `test_en` after the capture edge have no effect.
- R3: If `bist_done` is seen with `bist_pass` = 0, the block halts. In the halted state `rd_addr` holds 32'hFEED_0001, `fail_n` stays 0, and no boot-record read is ever issued.
- R4: If `bist_done` is seen with `bist_pass` = 1, `fail_n` goes high for exactly one cycle. Then `fail_n` drops to 0 and the bus check begins.
- R5: The bus check is always run. It issues 8 reads at addresses BASE, BASE+4, and so on up to BASE+28. Each read holds `rd_req` and its address until a cycle with `rd_valid` high accepts `rd_data`, and the next address follows in the cycle after acceptance.
- R6: If the 32-bit wraparound sum of the 8 words plus 32'hFFFF_FFFF is zero, `fail_n` goes to 1 and `run_ok` goes to 1 in the cycle after the last acceptance. Both then stay at 1 until reset.
- R7: If that sum is non-zero, the block halts with `rd_addr` = 32'hFEED_0002 and `fail_n` = 0. While halted, `rd_valid`, `bist_done` and `test_en` have no effect until reset.
- R8: When the internal test is skipped, `fail_n` stays at 0 without a break from reset until the bus check ends.
- R9: `fail_n` is a registered output. If `sys_err` is high at a clock edge, `fail_n` is 0 after that edge in any state, and the sequence state is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| test_en | input | 1 | Selects running (1) or skipping (0) the internal test |
| sys_err | input | 1 | External system error, forces fail low |
| bist_start | output | 1 | Run request to the internal test engine |
| bist_done | input | 1 | Internal test engine finished |
| bist_pass | input | 1 | Internal test verdict, valid with bist_done |
| rd_req | output | 1 | Boot-record read request |
| rd_addr | output | ADDR_W | Read address, or the failure code while halted |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DATA_W | Read response word |
| fail_n | output | 1 | Active-low fail indication |
| run_ok | output | 1 | Normal operation may begin |

## Verification
The hardest case to reach from the ports is a checksum that misses zero by a small amount. Most random word sets fail for obvious reasons, so a sensitivity problem in the adder or the beat counter could go unnoticed. The stimulus therefore builds each boot record so that its total is exactly zero, using the seed and the wraparound arithmetic. It then perturbs one word at a time, at every position, by a single bit, and checks that each perturbation, and only that, causes a halt. Response latencies vary per word, so the request-hold behaviour and the address stepping are exercised under stalls as well.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_BIST = 3'd1,
    ST_SKIP = 3'd2,
    ST_GAP  = 3'd3,
    ST_BUS  = 3'd4,
    ST_RUN  = 3'd5,
    ST_HALT = 3'd6
  } seq_state_e;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_BIST = 2'd1,
    FC_BUS  = 2'd2
  } fail_src_e;

  function automatic logic phase_holds_fail(seq_state_e s);
    return (s == ST_INIT) || (s == ST_BIST) || (s == ST_SKIP) ||
           (s == ST_BUS)  || (s == ST_HALT);
  endfunction

endpackage

// File: rtl/selftest_fsm.sv
module selftest_fsm
  import selftest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_en,
  input  logic       bist_done,
  input  logic       bist_pass,
  input  logic       bus_last,
  input  logic       bus_ok,
  output seq_state_e st_o,
  output seq_state_e nxt_o,
  output fail_src_e  nxt_src_o
);

  seq_state_e st_q;
  seq_state_e nxt;
  fail_src_e  nxt_src;

  // next-state logic
  always_comb begin
    nxt     = st_q;
    nxt_src = FC_NONE;
    case (st_q)
      ST_INIT: nxt = test_en ? ST_BIST : ST_SKIP;
      ST_BIST: begin
        if (bist_done) begin
          if (bist_pass) begin
            nxt = ST_GAP;
          end else begin
            nxt     = ST_HALT;
            nxt_src = FC_BIST;
          end
        end
      end
      ST_SKIP: nxt = ST_BUS;
      ST_GAP:  nxt = ST_BUS;
      ST_BUS: begin
        if (bus_last) begin
          if (bus_ok) begin
            nxt = ST_RUN;
          end else begin
            nxt     = ST_HALT;
            nxt_src = FC_BUS;
          end
        end
      end
      default: nxt = st_q;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_INIT;
    end else begin
      st_q <= nxt;
    end
  end

  assign st_o      = st_q;
  assign nxt_o     = nxt;
  assign nxt_src_o = nxt_src;

endmodule

// File: rtl/boot_csum.sv
module boot_csum #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned N_WORDS   = 8,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int unsigned STEP      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] scan_addr,
  output logic              last_beat,
  output logic              sum_ok
);

  localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(N_WORDS - 1);
  localparam logic [ADDR_W-1:0] STEP_A   = ADDR_W'(STEP);
  localparam logic [DATA_W-1:0] SEED     = '1;

  logic [IDX_W-1:0]  idx_q,  idx_d;
  logic [DATA_W-1:0] acc_q,  acc_d;
  logic [DATA_W-1:0] acc_sum;
  logic              beat;
  logic              upd_en;

  assign beat    = active & rd_valid;
  assign acc_sum = acc_q + rd_data;

  // next-value logic: cleared whenever the scan is not running
  always_comb begin
    idx_d  = idx_q;
    acc_d  = acc_q;
    upd_en = 1'b0;
    if (!active) begin
      upd_en = 1'b1;
      idx_d  = '0;
      acc_d  = SEED;
    end else if (beat) begin
      upd_en = 1'b1;
      idx_d  = idx_q + 1'b1;
      acc_d  = acc_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= SEED;
    end else if (upd_en) begin
      idx_q <= idx_d;
      acc_q <= acc_d;
    end
  end

  assign rd_req    = active;
  assign scan_addr = BASE + (ADDR_W'(idx_q) * STEP_A);
  assign last_beat = beat && (idx_q == IDX_LAST);
  assign sum_ok    = (acc_sum == '0);

endmodule

// File: rtl/fail_out.sv
module fail_out
  import selftest_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] CODE_BIST = '0,
  parameter logic [ADDR_W-1:0] CODE_BUS  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        st,
  input  seq_state_e        nxt,
  input  fail_src_e         nxt_src,
  input  logic              sys_err,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic              fail_n,
  output logic [ADDR_W-1:0] addr_bus,
  output logic              run_ok
);

  logic              fail_n_q, fail_n_d;
  logic [ADDR_W-1:0] code_q,   code_d;
  logic              code_en;

  always_comb begin
    fail_n_d = !(phase_holds_fail(nxt) || sys_err);
    code_en  = (nxt == ST_HALT) && (st != ST_HALT);
    code_d   = (nxt_src == FC_BIST) ? CODE_BIST : CODE_BUS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_n_q <= 1'b0;
    end else begin
      fail_n_q <= fail_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  always_comb begin
    case (st)
      ST_HALT: addr_bus = code_q;
      ST_BUS:  addr_bus = scan_addr;
      default: addr_bus = '0;
    endcase
  end

  assign fail_n = fail_n_q;
  assign run_ok = (st == ST_RUN);

endmodule

// File: rtl/selftest_seq.sv
module selftest_seq
  import selftest_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       N_WORDS   = 8,
  parameter logic [ADDR_W-1:0] BASE      = 32'h0000_0100,
  parameter int unsigned       STEP      = 4,
  parameter logic [ADDR_W-1:0] CODE_BIST = 32'hFEED_0001,
  parameter logic [ADDR_W-1:0] CODE_BUS  = 32'hFEED_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              sys_err,
  output logic              bist_start,
  input  logic              bist_done,
  input  logic              bist_pass,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              fail_n,
  output logic              run_ok
);

  seq_state_e        st_w;
  seq_state_e        nxt_w;
  fail_src_e         src_w;
  logic              scan_last;
  logic              scan_ok;
  logic [ADDR_W-1:0] scan_addr;

  selftest_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .bist_done (bist_done),
    .bist_pass (bist_pass),
    .bus_last  (scan_last),
    .bus_ok    (scan_ok),
    .st_o      (st_w),
    .nxt_o     (nxt_w),
    .nxt_src_o (src_w)
  );

  boot_csum #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .N_WORDS (N_WORDS),
    .BASE    (BASE),
    .STEP    (STEP)
  ) u_csum (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (st_w == ST_BUS),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_req    (rd_req),
    .scan_addr (scan_addr),
    .last_beat (scan_last),
    .sum_ok    (scan_ok)
  );

  fail_out #(
    .ADDR_W    (ADDR_W),
    .CODE_BIST (CODE_BIST),
    .CODE_BUS  (CODE_BUS)
  ) u_fail (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_w),
    .nxt       (nxt_w),
    .nxt_src   (src_w),
    .sys_err   (sys_err),
    .scan_addr (scan_addr),
    .fail_n    (fail_n),
    .addr_bus  (rd_addr),
    .run_ok    (run_ok)
  );

  assign bist_start = (st_w == ST_BIST);

endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_err,
  input logic              bist_start,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              scan_last,
  input logic              halted,
  input logic              fail_n,
  input logic              run_ok
);

  // R2 / R5: the test engine and the boot-record scan never overlap
  a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |-> !rd_req);

  // R5: a stalled request holds its address
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R5: an accepted non-final beat advances the address by one word
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid && !scan_last) |=>
      (rd_req && (rd_addr == $past(rd_addr) + ADDR_W'(STEP))));

  // R6: running state is sticky and keeps fail released unless sys_err
  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_ok |=> run_ok);

  a_r6_run_released: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && !sys_err) |=> fail_n);

  // R7 / R3: halt is terminal, code and fail held, no reads
  a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(rd_addr) && !fail_n && !rd_req && !run_ok));

  // R9: system error forces fail low after the edge
  a_r9_syserr_fail: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |=> !fail_n);

endmodule

bind selftest_seq selftest_seq_chk #(
  .ADDR_W (ADDR_W),
  .STEP   (STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sys_err    (sys_err),
  .bist_start (bist_start),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .rd_addr    (rd_addr),
  .scan_last  (scan_last),
  .halted     (st_w == selftest_pkg::ST_HALT),
  .fail_n     (fail_n),
  .run_ok     (run_ok)
);

// File: tb/sim_selftest_seq.sv
`timescale 1ns/1ps
module sim_selftest_seq;

  localparam logic [31:0] BASE  = 32'h0000_0100;
  localparam logic [31:0] C_BI  = 32'hFEED_0001;
  localparam logic [31:0] C_BUS = 32'hFEED_0002;

  logic        clk = 1'b0;
  logic        rst_n, test_en, sys_err, bist_done, bist_pass, rd_valid;
  logic [31:0] rd_data;
  logic        bist_start, rd_req, fail_n, run_ok;
  logic [31:0] rd_addr;

  int n_run  = 0;
  int n_fail = 0;
  int hi_cnt = 0;
  logic [31:0] wbuf [8];

  always #2.5 clk = ~clk;

  selftest_seq u0 (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .sys_err(sys_err),
    .bist_start(bist_start), .bist_done(bist_done), .bist_pass(bist_pass),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .fail_n(fail_n), .run_ok(run_ok)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (fail_n) hi_cnt++;
  endtask

  // reset, R1 checks, release; returns at the negedge before the capture edge
  task automatic start(input bit te);
    rst_n = 1'b0; test_en = te; sys_err = 1'b0; bist_done = 1'b0;
    bist_pass = 1'b0; rd_valid = 1'b0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk(fail_n == 1'b0, "R1", "fail_n in reset", 32'(fail_n), 0);
    chk(!run_ok && !rd_req && !bist_start, "R1", "outputs idle in reset",
        {29'd0, run_ok, rd_req, bist_start}, 0);
    rst_n  = 1'b1;
    hi_cnt = 0;
  endtask

  // internal test phase; returns at negedge where scan is visible (pass)
  task automatic bist_phase(input bit pass, input int lat, input bit flip_te);
    tick();
    chk(bist_start == 1'b1, "R2", "bist_start after capture", 32'(bist_start), 1);
    chk(fail_n == 1'b0, "R1", "fail_n low in test", 32'(fail_n), 0);
    if (flip_te) test_en = 1'b0;
    for (int i = 0; i < lat; i++) begin
      tick();
      chk(bist_start == 1'b1, "R2", "bist_start held", 32'(bist_start), 1);
    end
    bist_done = 1'b1; bist_pass = pass;
    tick();
    bist_done = 1'b0; bist_pass = 1'b0;
    chk(bist_start == 1'b0, "R2", "bist_start drops after done", 32'(bist_start), 0);
    if (pass) begin
      chk(fail_n == 1'b1 && !rd_req, "R4", "fail released in gap", 32'(fail_n), 1);
      tick();
      chk(fail_n == 1'b0, "R4", "fail reasserted for scan", 32'(fail_n), 0);
      chk(rd_req == 1'b1, "R5", "scan starts", 32'(rd_req), 1);
    end
  endtask

  task automatic skip_phase();
    tick();
    chk(bist_start == 1'b0, "R2", "no bist when disabled", 32'(bist_start), 0);
    tick();
    chk(rd_req == 1'b1 && rd_addr == BASE, "R5", "scan starts after skip", rd_addr, BASE);
  endtask

  // serve the 8 reads from wbuf and check the outcome
  task automatic bus_phase(input int lat_seed, input bit te_path);
    logic [31:0] s = 32'hFFFF_FFFF;
    bit good;
    for (int k = 0; k < 8; k++) s = s + wbuf[k];
    good = (s == 32'd0);
    for (int k = 0; k < 8; k++) begin
      for (int d = 0; d < (k + lat_seed) % 3; d++) begin
        chk(rd_req && rd_addr == BASE + 32'(4 * k), "R5", "stalled request holds",
            rd_addr, BASE + 32'(4 * k));
        tick();
      end
      chk(rd_req && rd_addr == BASE + 32'(4 * k), "R5", "read address",
          rd_addr, BASE + 32'(4 * k));
      chk(fail_n == 1'b0, "R8", "fail low during scan", 32'(fail_n), 0);
      rd_valid = 1'b1; rd_data = wbuf[k];
      tick();
      rd_valid = 1'b0;
    end
    if (good) begin
      chk(fail_n && run_ok, "R6", "released after good sum", {30'd0, fail_n, run_ok}, 3);
      chk(!rd_req, "R6", "no further reads", 32'(rd_req), 0);
      chk(hi_cnt == (te_path ? 2 : 1), "R8", "fail-high cycle count",
          32'(hi_cnt), te_path ? 2 : 1);
    end else begin
      chk(!fail_n && !run_ok, "R7", "halted after bad sum", {30'd0, fail_n, run_ok}, 0);
      chk(rd_addr == C_BUS, "R7", "bus fail code", rd_addr, C_BUS);
    end
  endtask

  // stimulate while halted; nothing may change
  task automatic halt_hold(input logic [31:0] code, input string req);
    for (int i = 0; i < 4; i++) begin
      rd_valid = i[0]; bist_done = ~i[0]; bist_pass = 1'b1; test_en = i[1];
      rd_data = 32'h0;
      tick();
      chk(!fail_n && !run_ok && !rd_req && rd_addr == code, req, "halt holds",
          rd_addr, code);
    end
    rd_valid = 1'b0; bist_done = 1'b0; bist_pass = 1'b0;
  endtask

  task automatic make_good(input int seed);
    logic [31:0] s7 = '0;
    for (int k = 0; k < 7; k++) begin
      wbuf[k] = 32'(seed) * 32'h9E37_79B9 + 32'(k) * 32'h7F4A_7C15;
      s7 = s7 + wbuf[k];
    end
    wbuf[7] = 32'd1 - s7;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    // R6 + R4: test enabled, passing, good record; then R9 in run state
    make_good(1);
    start(1'b1); bist_phase(1'b1, 2, 1'b0); bus_phase(0, 1'b1);
    sys_err = 1'b1;
    tick();
    chk(fail_n == 1'b0 && run_ok, "R9", "sys_err forces fail", 32'(fail_n), 0);
    sys_err = 1'b0;
    tick();
    chk(fail_n == 1'b1 && run_ok, "R9", "fail returns after sys_err", 32'(fail_n), 1);

    // R8: bypassed test across several records
    for (int seed = 2; seed < 6; seed++) begin
      make_good(seed);
      start(1'b0); skip_phase(); bus_phase(seed, 1'b0);
    end

    // R2: test_en dropped after capture is ignored
    make_good(7);
    start(1'b1); bist_phase(1'b1, 5, 1'b1); bus_phase(1, 1'b1);

    // R3: internal test failure
    start(1'b1); bist_phase(1'b0, 1, 1'b0);
    chk(rd_addr == C_BI && !fail_n, "R3", "bist fail code", rd_addr, C_BI);
    halt_hold(C_BI, "R3");

    // R7: single-bit corruption at every word position
    for (int k = 0; k < 8; k++) begin
      make_good(10 + k);
      wbuf[k] = wbuf[k] ^ (32'd1 << k);
      start(k[0]);
      if (k[0]) bist_phase(1'b1, 0, 1'b0); else skip_phase();
      bus_phase(k, k[0]);
      halt_hold(C_BUS, "R7");
    end

    // R6: carries wrap through bit 31
    for (int k = 0; k < 7; k++) wbuf[k] = 32'hFFFF_FFFF;
    wbuf[7] = 32'd8;
    start(1'b0); skip_phase(); bus_phase(2, 1'b0);

    // R1: reset out of the halted state
    start(1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule